// File: doc/BRIEF.md
# Vector Integer Arithmetic Opcode Decoder

This block takes one 32-bit instruction word per cycle and, when it carries the vector major opcode (`1010111`) with an integer operand group selected in funct3, turns it into one opcode class from a per-instruction enumeration. The three integer groups are vector-vector, vector-scalar and vector-immediate. Related forms of one operation, such as the three forms of an add, share a class. The operand group is reported on a separate output. The decode is nested: the outer selection is on funct3, and the inner selection on funct6 depends on the group and, for one funct6 value, on the mask bit.

The block does not interpret masking policy or the current vector type. The mask bit and the register fields pass through unchanged for a later rename stage. Words outside the integer groups, including other vector groups and non-vector opcodes, come out as a neutral "other" class. An integer-group word whose funct6 is not defined in its group raises an illegal flag. All outputs are registered, and a result appears one clock after its word is presented with `in_valid`.

Top module: `viadec_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `out_valid`=0, `out_op`=0 (invalid class), `out_illegal`=0, `out_nreg`=0 and `out_grp`=3.
- R2: A word presented with `in_valid`=1 is decoded and its result appears on the outputs after exactly one rising clock edge, with `out_valid`=1.
- R3: If bits [6:0] are not `1010111`, or funct3 (bits [14:12]) is not 000, 100 or 011, then `out_op` is the other class (value 1), `out_illegal`=0, `out_int_group`=0 and `out_grp`=3.
- R4: `out_grp` is 0 for funct3=000 (vector-vector), 1 for funct3=100 (vector-scalar) and 2 for funct3=011 (vector-immediate), and `out_int_group`=1 in those three cases.
- R5: funct6 (bits [31:26]) = 0x17 decodes as the merge class when vm (bit 25) is 0 and as the vector-move class when vm is 1, in all three groups.
- R6: funct6=0x11 gives the add-carry-mask class and funct6=0x13 gives the subtract-borrow-mask class whatever vm is. 0x13 is illegal in the vector-immediate group.
- R7: funct6=0x0e decodes as the 16-bit-index gather class in the vector-vector group and as the slide-up class in the other two groups.
- R8: In the vector-immediate group, funct6=0x27 decodes as the whole-register move class when bits [19:15] are 0, 1, 3 or 7, with `out_nreg` = that value + 1. Any other value there is illegal.
- R9: A funct6 that is not defined in the selected integer group sets `out_illegal`=1 and `out_op`=0.
- R10: `out_vm`, `out_vd`, `out_vs2` and `out_src1` equal bits 25, [11:7], [24:20] and [19:15] of the decoded word.
- R11: `out_nreg` is 0 for every class other than the whole-register move.
- R12: The other defined funct6 values of each group map to their own per-operation classes from the shared package enumeration.
- R13: A cycle with `in_valid`=0 drops `out_valid` to 0 at the next edge and leaves every other output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_inst | input | 32 | Instruction word |
| out_valid | output | 1 | Registered result valid |
| out_op | output | 8 | Opcode class (0 invalid, 1 other) |
| out_illegal | output | 1 | Undefined funct6 in an integer group |
| out_int_group | output | 1 | Word belongs to an integer operand group |
| out_grp | output | 2 | 0 vector-vector, 1 vector-scalar, 2 vector-immediate, 3 none |
| out_vm | output | 1 | Mask bit, passed through |
| out_vd | output | 5 | Destination field |
| out_vs2 | output | 5 | Second source field |
| out_src1 | output | 5 | First source / scalar register / immediate field |
| out_nreg | output | 4 | Register count for a whole-register move, else 0 |

## Verification
The hardest case to reach is the whole-register move. It needs the vector-immediate group, funct6 0x27 and one of only four immediate values, so a sweep that holds the immediate fixed would either miss it or never hit its illegal neighbours. The stimulus sweeps every funct6 with both mask values in all three groups. It then runs all 32 immediate values under funct6 0x27 in each group, so the 0x27 aliasing is covered for every group. Words from the other funct3 groups and from foreign opcodes are added, and so are idle cycles carrying different words, to show that the outputs hold.

// File: rtl/viadec_pkg.sv
package viadec_pkg;
  localparam int INST_W = 32;
  localparam int OP_W   = 8;
  localparam int REG_W  = 5;
  localparam int F6_W   = 6;
  localparam int NREG_W = 4;
  localparam logic [6:0] VEC_MAJOR = 7'b1010111;

  typedef enum logic [1:0] {
    GRP_VV   = 2'd0,
    GRP_VX   = 2'd1,
    GRP_VI   = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  typedef enum logic [OP_W-1:0] {
    IV_INVALID, IV_OTHER,
    IV_ADD, IV_SUB, IV_RSUB, IV_MINU, IV_MIN, IV_MAXU, IV_MAX,
    IV_AND, IV_OR, IV_XOR, IV_RGATHER, IV_RGATHEREI16,
    IV_SLIDEUP, IV_SLIDEDOWN,
    IV_ADC, IV_MADC, IV_SBC, IV_MSBC, IV_MERGE, IV_MV_V,
    IV_MSEQ, IV_MSNE, IV_MSLTU, IV_MSLT, IV_MSLEU, IV_MSLE,
    IV_MSGTU, IV_MSGT,
    IV_SADDU, IV_SADD, IV_SSUBU, IV_SSUB,
    IV_SLL, IV_SMUL, IV_MVNR, IV_SRL, IV_SRA, IV_SSRL, IV_SSRA,
    IV_NSRL, IV_NSRA, IV_NCLIPU, IV_NCLIP,
    IV_WREDSUMU, IV_WREDSUM
  } iv_op_e;
endpackage

// File: rtl/viadec_group.sv
module viadec_group
  import viadec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  output grp_e       grp,
  output logic       in_scope
);
  always_comb begin
    grp = GRP_NONE;
    if (opcode == VEC_MAJOR) begin
      case (funct3)
        3'b000:  grp = GRP_VV;
        3'b100:  grp = GRP_VX;
        3'b011:  grp = GRP_VI;
        default: grp = GRP_NONE;
      endcase
    end
    in_scope = (grp != GRP_NONE);
  end
endmodule

// File: rtl/viadec_lookup.sv
module viadec_lookup
  import viadec_pkg::*;
(
  input  grp_e              grp,
  input  logic              in_scope,
  input  logic [F6_W-1:0]   f6,
  input  logic              vm,
  input  logic [REG_W-1:0]  imm,
  output iv_op_e            op,
  output logic              illegal,
  output logic [NREG_W-1:0] nreg
);
  always_comb begin
    op      = IV_INVALID;
    illegal = 1'b0;
    nreg    = '0;
    if (!in_scope) begin
      op = IV_OTHER;
    end else begin
      case (grp)
        GRP_VV: begin
          case (f6)
            6'h00: op = IV_ADD;      6'h02: op = IV_SUB;
            6'h04: op = IV_MINU;     6'h05: op = IV_MIN;
            6'h06: op = IV_MAXU;     6'h07: op = IV_MAX;
            6'h09: op = IV_AND;      6'h0a: op = IV_OR;
            6'h0b: op = IV_XOR;      6'h0c: op = IV_RGATHER;
            6'h0e: op = IV_RGATHEREI16;
            6'h10: op = IV_ADC;      6'h11: op = IV_MADC;
            6'h12: op = IV_SBC;      6'h13: op = IV_MSBC;
            6'h17: op = vm ? IV_MV_V : IV_MERGE;
            6'h18: op = IV_MSEQ;     6'h19: op = IV_MSNE;
            6'h1a: op = IV_MSLTU;    6'h1b: op = IV_MSLT;
            6'h1c: op = IV_MSLEU;    6'h1d: op = IV_MSLE;
            6'h20: op = IV_SADDU;    6'h21: op = IV_SADD;
            6'h22: op = IV_SSUBU;    6'h23: op = IV_SSUB;
            6'h25: op = IV_SLL;      6'h27: op = IV_SMUL;
            6'h28: op = IV_SRL;      6'h29: op = IV_SRA;
            6'h2a: op = IV_SSRL;     6'h2b: op = IV_SSRA;
            6'h2c: op = IV_NSRL;     6'h2d: op = IV_NSRA;
            6'h2e: op = IV_NCLIPU;   6'h2f: op = IV_NCLIP;
            6'h30: op = IV_WREDSUMU; 6'h31: op = IV_WREDSUM;
            default: illegal = 1'b1;
          endcase
        end
        GRP_VX: begin
          case (f6)
            6'h00: op = IV_ADD;      6'h02: op = IV_SUB;
            6'h03: op = IV_RSUB;
            6'h04: op = IV_MINU;     6'h05: op = IV_MIN;
            6'h06: op = IV_MAXU;     6'h07: op = IV_MAX;
            6'h09: op = IV_AND;      6'h0a: op = IV_OR;
            6'h0b: op = IV_XOR;      6'h0c: op = IV_RGATHER;
            6'h0e: op = IV_SLIDEUP;  6'h0f: op = IV_SLIDEDOWN;
            6'h10: op = IV_ADC;      6'h11: op = IV_MADC;
            6'h12: op = IV_SBC;      6'h13: op = IV_MSBC;
            6'h17: op = vm ? IV_MV_V : IV_MERGE;
            6'h18: op = IV_MSEQ;     6'h19: op = IV_MSNE;
            6'h1a: op = IV_MSLTU;    6'h1b: op = IV_MSLT;
            6'h1c: op = IV_MSLEU;    6'h1d: op = IV_MSLE;
            6'h1e: op = IV_MSGTU;    6'h1f: op = IV_MSGT;
            6'h20: op = IV_SADDU;    6'h21: op = IV_SADD;
            6'h22: op = IV_SSUBU;    6'h23: op = IV_SSUB;
            6'h25: op = IV_SLL;      6'h27: op = IV_SMUL;
            6'h28: op = IV_SRL;      6'h29: op = IV_SRA;
            6'h2a: op = IV_SSRL;     6'h2b: op = IV_SSRA;
            6'h2c: op = IV_NSRL;     6'h2d: op = IV_NSRA;
            6'h2e: op = IV_NCLIPU;   6'h2f: op = IV_NCLIP;
            default: illegal = 1'b1;
          endcase
        end
        GRP_VI: begin
          case (f6)
            6'h00: op = IV_ADD;      6'h03: op = IV_RSUB;
            6'h09: op = IV_AND;      6'h0a: op = IV_OR;
            6'h0b: op = IV_XOR;      6'h0c: op = IV_RGATHER;
            6'h0e: op = IV_SLIDEUP;  6'h0f: op = IV_SLIDEDOWN;
            6'h10: op = IV_ADC;      6'h11: op = IV_MADC;
            6'h17: op = vm ? IV_MV_V : IV_MERGE;
            6'h18: op = IV_MSEQ;     6'h19: op = IV_MSNE;
            6'h1c: op = IV_MSLEU;    6'h1d: op = IV_MSLE;
            6'h1e: op = IV_MSGTU;    6'h1f: op = IV_MSGT;
            6'h20: op = IV_SADDU;    6'h21: op = IV_SADD;
            6'h25: op = IV_SLL;
            6'h27: begin
              // whole-register move: immediate holds count minus one
              case (imm)
                5'd0, 5'd1, 5'd3, 5'd7: begin
                  op   = IV_MVNR;
                  nreg = NREG_W'(imm) + NREG_W'(1);
                end
                default: illegal = 1'b1;
              endcase
            end
            6'h28: op = IV_SRL;      6'h29: op = IV_SRA;
            6'h2a: op = IV_SSRL;     6'h2b: op = IV_SSRA;
            6'h2c: op = IV_NSRL;     6'h2d: op = IV_NSRA;
            6'h2e: op = IV_NCLIPU;   6'h2f: op = IV_NCLIP;
            default: illegal = 1'b1;
          endcase
        end
        default: op = IV_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/viadec_top.sv
module viadec_top
  import viadec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INST_W-1:0]    in_inst,
  output logic                 out_valid,
  output logic [OP_W-1:0]      out_op,
  output logic                 out_illegal,
  output logic                 out_int_group,
  output logic [1:0]           out_grp,
  output logic                 out_vm,
  output logic [REG_W-1:0]     out_vd,
  output logic [REG_W-1:0]     out_vs2,
  output logic [REG_W-1:0]     out_src1,
  output logic [NREG_W-1:0]    out_nreg
);
  grp_e              grp_c;
  logic              scope_c;
  iv_op_e            op_c;
  logic              illegal_c;
  logic [NREG_W-1:0] nreg_c;

  viadec_group u_group (
    .opcode   (in_inst[6:0]),
    .funct3   (in_inst[14:12]),
    .grp      (grp_c),
    .in_scope (scope_c)
  );

  viadec_lookup u_lookup (
    .grp      (grp_c),
    .in_scope (scope_c),
    .f6       (in_inst[31:26]),
    .vm       (in_inst[25]),
    .imm      (in_inst[19:15]),
    .op       (op_c),
    .illegal  (illegal_c),
    .nreg     (nreg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_op        <= IV_INVALID;
      out_illegal   <= 1'b0;
      out_int_group <= 1'b0;
      out_grp       <= GRP_NONE;
      out_vm        <= 1'b0;
      out_vd        <= '0;
      out_vs2       <= '0;
      out_src1      <= '0;
      out_nreg      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_op        <= op_c;
        out_illegal   <= illegal_c;
        out_int_group <= scope_c;
        out_grp       <= grp_c;
        out_vm        <= in_inst[25];
        out_vd        <= in_inst[11:7];
        out_vs2       <= in_inst[24:20];
        out_src1      <= in_inst[19:15];
        out_nreg      <= nreg_c;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && out_op == IV_INVALID && !out_illegal && out_nreg == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_op) && $stable(out_vd) && $stable(out_illegal)));

  a_r9_illegal_is_invalid: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_op == IV_INVALID && out_int_group));

  a_r3_outside_not_illegal: assert property (@(posedge clk) disable iff (rst)
    !out_int_group |-> (!out_illegal && out_grp == GRP_NONE));

  a_r8_nreg_power_of_two: assert property (@(posedge clk) disable iff (rst)
    (out_op == IV_MVNR) |-> ($countones(out_nreg) == 1 && out_grp == GRP_VI));

  a_r11_nreg_zero_else: assert property (@(posedge clk) disable iff (rst)
    (out_op != IV_MVNR) |-> (out_nreg == '0));

  a_r10_vd_passthrough: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_vd == $past(in_inst[11:7]) && out_vm == $past(in_inst[25])));
endmodule

// File: tb/viadec_top_test.sv
module viadec_top_test;
  import viadec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_inst = '0;
  logic        out_valid, out_illegal, out_int_group, out_vm;
  logic [7:0]  out_op;
  logic [1:0]  out_grp;
  logic [4:0]  out_vd, out_vs2, out_src1;
  logic [3:0]  out_nreg;

  always #5 clk = ~clk;

  viadec_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_inst(in_inst),
    .out_valid(out_valid), .out_op(out_op), .out_illegal(out_illegal),
    .out_int_group(out_int_group), .out_grp(out_grp), .out_vm(out_vm),
    .out_vd(out_vd), .out_vs2(out_vs2), .out_src1(out_src1),
    .out_nreg(out_nreg)
  );

  typedef struct {
    logic       valid;
    logic [7:0] op;
    logic       illegal;
    logic       scope;
    logic [1:0] grp;
    logic       vm;
    logic [4:0] vd, vs2, src1;
    logic [3:0] nreg;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // row: {allowed in VI, VX, VV, class}
  function automatic logic [10:0] row(input logic [5:0] f6);
    case (f6)
      6'h00: return {3'b111, 8'(IV_ADD)};
      6'h02: return {3'b011, 8'(IV_SUB)};
      6'h03: return {3'b110, 8'(IV_RSUB)};
      6'h04: return {3'b011, 8'(IV_MINU)};
      6'h05: return {3'b011, 8'(IV_MIN)};
      6'h06: return {3'b011, 8'(IV_MAXU)};
      6'h07: return {3'b011, 8'(IV_MAX)};
      6'h09: return {3'b111, 8'(IV_AND)};
      6'h0a: return {3'b111, 8'(IV_OR)};
      6'h0b: return {3'b111, 8'(IV_XOR)};
      6'h0c: return {3'b111, 8'(IV_RGATHER)};
      6'h0f: return {3'b110, 8'(IV_SLIDEDOWN)};
      6'h10: return {3'b111, 8'(IV_ADC)};
      6'h11: return {3'b111, 8'(IV_MADC)};
      6'h12: return {3'b011, 8'(IV_SBC)};
      6'h13: return {3'b011, 8'(IV_MSBC)};
      6'h18: return {3'b111, 8'(IV_MSEQ)};
      6'h19: return {3'b111, 8'(IV_MSNE)};
      6'h1a: return {3'b011, 8'(IV_MSLTU)};
      6'h1b: return {3'b011, 8'(IV_MSLT)};
      6'h1c: return {3'b111, 8'(IV_MSLEU)};
      6'h1d: return {3'b111, 8'(IV_MSLE)};
      6'h1e: return {3'b110, 8'(IV_MSGTU)};
      6'h1f: return {3'b110, 8'(IV_MSGT)};
      6'h20: return {3'b111, 8'(IV_SADDU)};
      6'h21: return {3'b111, 8'(IV_SADD)};
      6'h22: return {3'b011, 8'(IV_SSUBU)};
      6'h23: return {3'b011, 8'(IV_SSUB)};
      6'h25: return {3'b111, 8'(IV_SLL)};
      6'h27: return {3'b011, 8'(IV_SMUL)};
      6'h28: return {3'b111, 8'(IV_SRL)};
      6'h29: return {3'b111, 8'(IV_SRA)};
      6'h2a: return {3'b111, 8'(IV_SSRL)};
      6'h2b: return {3'b111, 8'(IV_SSRA)};
      6'h2c: return {3'b111, 8'(IV_NSRL)};
      6'h2d: return {3'b111, 8'(IV_NSRA)};
      6'h2e: return {3'b111, 8'(IV_NCLIPU)};
      6'h2f: return {3'b111, 8'(IV_NCLIP)};
      6'h30: return {3'b001, 8'(IV_WREDSUMU)};
      6'h31: return {3'b001, 8'(IV_WREDSUM)};
      default: return {3'b000, 8'(IV_INVALID)};
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [5:0] f6 = w[31:26];
    logic [2:0] f3 = w[14:12];
    logic [4:0] imm = w[19:15];
    logic [10:0] r;
    e.valid = 1'b1; e.vm = w[25]; e.vd = w[11:7];
    e.vs2 = w[24:20]; e.src1 = w[19:15];
    e.illegal = 1'b0; e.nreg = 4'd0; e.tag = "R12";
    e.scope = (w[6:0] == 7'b1010111) && (f3 == 3'b000 || f3 == 3'b100 || f3 == 3'b011);
    if (!e.scope) begin
      e.op = 8'(IV_OTHER); e.grp = 2'd3; e.tag = "R3";
      return e;
    end
    e.grp = (f3 == 3'b000) ? 2'd0 : (f3 == 3'b100) ? 2'd1 : 2'd2;
    r = row(f6);
    if (f6 == 6'h17) begin
      e.op = w[25] ? 8'(IV_MV_V) : 8'(IV_MERGE); e.tag = "R5";
    end else if (f6 == 6'h0e) begin
      e.op = (e.grp == 2'd0) ? 8'(IV_RGATHEREI16) : 8'(IV_SLIDEUP); e.tag = "R7";
    end else if (f6 == 6'h27 && e.grp == 2'd2) begin
      e.tag = "R8";
      if (imm == 5'd0 || imm == 5'd1 || imm == 5'd3 || imm == 5'd7) begin
        e.op = 8'(IV_MVNR); e.nreg = 4'(imm) + 4'd1;
      end else begin
        e.op = 8'(IV_INVALID); e.illegal = 1'b1;
      end
    end else if (!r[8 + e.grp]) begin
      e.op = 8'(IV_INVALID); e.illegal = 1'b1;
      e.tag = (f6 == 6'h13) ? "R6" : "R9";
    end else begin
      e.op = r[7:0];
      if (f6 == 6'h11 || f6 == 6'h13) e.tag = "R6";
    end
    return e;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: present one word and queue the expected outcome
  task automatic drive(input logic v, input logic [31:0] w);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    in_inst  = w;
    if (v) begin
      e = model(w);
      last_exp = e;
    end else begin
      e = last_exp;
      e.valid = 1'b0;
      e.tag = "R13";
    end
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm,
      input logic [4:0] vs2, input logic [4:0] s1, input logic [2:0] f3,
      input logic [4:0] vd, input logic [6:0] opc);
    return {f6, vm, vs2, s1, f3, vd, opc};
  endfunction

  // monitor: compare outputs one step after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag == "R13" ? "R13" : "R2", "valid", 32'(out_valid), 32'(e.valid));
      check(e.tag, "op", 32'(out_op), 32'(e.op));
      check(e.tag == "R3" ? "R3" : "R9", "illegal", 32'(out_illegal), 32'(e.illegal));
      check("R4", "group", {29'd0, out_int_group, out_grp}, {29'd0, e.scope, e.grp});
      check("R10", "fields", {16'd0, out_vm, out_vd, out_vs2, out_src1},
            {16'd0, e.vm, e.vd, e.vs2, e.src1});
      check(e.tag == "R8" ? "R8" : "R11", "nreg", 32'(out_nreg), 32'(e.nreg));
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs after reset, before any valid word
    check("R1", "valid", 32'(out_valid), 32'd0);
    check("R1", "op", 32'(out_op), 32'd0);
    check("R1", "illegal", 32'(out_illegal), 32'd0);
    check("R1", "nreg/grp", {28'd0, out_nreg, out_grp} , {28'd0, 4'd0, 2'd3});
    last_exp = model(32'd0);

    // full sweep of funct6 x vm x group (R4, R5, R6, R7, R9, R12)
    for (int g = 0; g < 3; g++) begin
      for (int f = 0; f < 64; f++) begin
        for (int m = 0; m < 2; m++) begin
          logic [2:0] f3 = (g == 0) ? 3'b000 : (g == 1) ? 3'b100 : 3'b011;
          k++;
          drive(1'b1, mk(6'(f), 1'(m), 5'(k * 7), 5'(k * 11 + 2), f3,
                         5'(k * 3 + 1), 7'b1010111));
        end
      end
    end
    // R8: every immediate under funct6 0x27 in each group
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < 32; i++) begin
        logic [2:0] f3 = (g == 0) ? 3'b000 : (g == 1) ? 3'b100 : 3'b011;
        drive(1'b1, mk(6'h27, 1'(i), 5'(i + 3), 5'(i), f3, 5'(31 - i), 7'b1010111));
      end
    end
    // R3: other funct3 groups and foreign opcodes
    for (int f3 = 0; f3 < 8; f3++) begin
      drive(1'b1, mk(6'h00, 1'b1, 5'd4, 5'd5, 3'(f3), 5'd6, 7'b1010111));
      drive(1'b1, mk(6'h17, 1'b0, 5'd9, 5'd1, 3'(f3), 5'd2, 7'b0110011));
      drive(1'b1, mk(6'h27, 1'b1, 5'd0, 5'd1, 3'(f3), 5'd8, 7'b0000111));
    end
    // R13: idle cycles with changing words must not alter outputs
    drive(1'b1, mk(6'h27, 1'b1, 5'd2, 5'd3, 3'b011, 5'd17, 7'b1010111));
    drive(1'b0, mk(6'h35, 1'b0, 5'd9, 5'd9, 3'b000, 5'd9, 7'b1010111));
    drive(1'b0, mk(6'h00, 1'b1, 5'd1, 5'd1, 3'b100, 5'd1, 7'b1010111));
    drive(1'b1, mk(6'h0e, 1'b0, 5'd7, 5'd7, 3'b000, 5'd7, 7'b1010111));
    drive(1'b0, 32'hFFFF_FFFF);
    drive(1'b0, 32'd0);
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule